// File: doc/BRIEF.md
# Saturating Serial Sample Output Master

This block sits after a decimation filter. It accepts signed samples wider than 16 bits, clamps each one to a 16-bit two's complement code, and sends the result out on a master-mode serial port. The block generates its own serial clock by dividing the system clock, and it also generates its own frame sync. A receiver only has to listen.

Every frame is 17 serial clock periods long. The first period is a frame sync slot, and the 16 data bits follow it. The frame sync, serial clock and data lines each come with an inverted twin for differential or dual-polarity routing.

An out-of-range flag reports whether the word in the current frame was clipped. The flag moves only on a falling serial clock edge, so a receiver that captures data on falling edges sees the flag and the data settle together.

Samples arrive on a valid strobe at any time. A single hold register keeps the newest clamped sample until the next frame boundary loads it into the shift register. Frames run back to back, so when no new sample has come in, the previous word goes out again.

Top module: `sat_serial_master`

## Requirements
- R1: A sample from -32768 to 32767 inclusive, the two ends included, is sent unchanged as its low 16 bits in two's complement, and the flag stays low for that frame.
- R2: A sample greater than 32767 is sent as 7FFFh, and the out-of-range flag is high for that frame.
- R3: A sample less than -32768 is sent as 8000h, and the out-of-range flag is high for that frame.
- R4: The flag stays high through back-to-back frames that carry clipped words. It returns low in the first frame whose word was in range.
- R5: The flag changes value only in the system clock cycle in which the serial clock falls. The new value is visible from the first falling edge of the frame, which is the one inside the frame sync slot, and it holds for the whole frame.
- R6: The serial clock period is DIV system clocks, high for DIV/2 and low for DIV/2. Frame sync is high for exactly one serial clock period, and 16 data periods follow before the next frame sync.
- R7: Data and frame sync change only in the cycle in which the serial clock rises. Data is low during the frame sync slot, and the bits then go out MSB first.
- R8: A sample is loaded into the shift register only at a frame start, so a sample taken mid-frame goes out in the following frame. If several samples arrive within one frame, the newest wins. If none arrives, the previous word is sent again.
- R9: Each complementary output is always the inverse of its twin.
- R10: While reset is asserted, the serial clock, frame sync, data and flag are low and their complements are high. The stored sample is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | IN_W | Signed sample from the filter |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| sclk | output | 1 | Generated serial clock |
| sclk_n | output | 1 | Inverted serial clock |
| fsync | output | 1 | Frame sync, high for one serial period |
| fsync_n | output | 1 | Inverted frame sync |
| sdata | output | 1 | Serial data, MSB first |
| sdata_n | output | 1 | Inverted serial data |
| oor | output | 1 | Out-of-range flag for the current frame |

## Verification
The bench sweeps samples within two codes of each clipping limit. A comparison that is off by one would clamp 32767 or -32768, or let 32768 or -32769 wrap to the opposite sign. Consecutive clipped frames followed by an in-range frame catch a flag that clears too early or never falls. An edge monitor catches a flag or a data bit that moves on the wrong serial clock edge. Mid-frame samples, two samples in one frame and frames with no sample expose a design that loads immediately, keeps the older sample, or stops sending when idle.

// File: rtl/sat_serial_master.sv
module sat_serial_master #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int DIV   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] smp_in,
  input  logic                   smp_vld,
  output logic                   sclk,
  output logic                   sclk_n,
  output logic                   fsync,
  output logic                   fsync_n,
  output logic                   sdata,
  output logic                   sdata_n,
  output logic                   oor
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int SW   = $clog2(OUT_W + 1);
  localparam logic signed [IN_W-1:0] POS_LIM = IN_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM - IN_W'(1);

  logic [PW-1:0]    ph;
  logic [SW-1:0]    slot;
  logic [OUT_W-1:0] sh, hold_w;
  logic             hold_o, frm_o;
  logic             sclk_q, fs_q, dat_q, oor_q;

  wire over  = smp_in > POS_LIM;
  wire under = smp_in < NEG_LIM;
  wire rise  = ph == PW'(DIV - 1);
  wire fall  = ph == PW'(HALF - 1);
  wire last  = slot == SW'(OUT_W);

  wire [OUT_W-1:0] clamped = over  ? {1'b0, {(OUT_W-1){1'b1}}} :
                             under ? {1'b1, {(OUT_W-1){1'b0}}} :
                                     smp_in[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      slot   <= SW'(OUT_W);
      sh     <= '0;
      hold_w <= '0;
      hold_o <= 1'b0;
      frm_o  <= 1'b0;
      sclk_q <= 1'b0;
      fs_q   <= 1'b0;
      dat_q  <= 1'b0;
      oor_q  <= 1'b0;
    end else begin
      ph <= rise ? '0 : ph + PW'(1);
      if (smp_vld) begin
        hold_w <= clamped;
        hold_o <= over | under;
      end
      if (rise) begin
        sclk_q <= 1'b1;
        if (last) begin
          slot  <= '0;
          fs_q  <= 1'b1;
          dat_q <= 1'b0;
          sh    <= hold_w;
          frm_o <= hold_o;
        end else begin
          slot  <= slot + SW'(1);
          fs_q  <= 1'b0;
          dat_q <= sh[OUT_W-1];
          sh    <= sh << 1;
        end
      end else if (fall) begin
        sclk_q <= 1'b0;
        oor_q  <= frm_o;
      end
    end
  end

  assign sclk    = sclk_q;
  assign sclk_n  = ~sclk_q;
  assign fsync   = fs_q;
  assign fsync_n = ~fs_q;
  assign sdata   = dat_q;
  assign sdata_n = ~dat_q;
  assign oor     = oor_q;
endmodule

module sat_serial_master_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic fsync,
  input logic sdata,
  input logic oor
);
  int fs_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      fs_cnt <= fsync ? fs_cnt + 1 : 0;
      hi_cnt <= sclk ? hi_cnt + 1 : 0;
    end
  end

  a_r5_oor_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oor) |-> $fell(sclk));
  a_r7_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $rose(sclk));
  a_r7_fsync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $rose(sclk));
  a_r6_fsync_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> fs_cnt == DIV);
  a_r6_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_cnt == DIV / 2);
endmodule

bind sat_serial_master sat_serial_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdata(sdata), .oor(oor)
);

// File: tb/tb_sat_serial_master.sv
module tb_sat_serial_master;
  localparam int CLK_PER = 10;
  localparam int IN_W    = 24;
  localparam int DIV     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [IN_W-1:0] smp_in = '0;
  logic smp_vld = 1'b0;
  logic sclk, sclk_n, fsync, fsync_n, sdata, sdata_n, oor;

  sat_serial_master #(.IN_W(IN_W), .OUT_W(16), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
    .sclk(sclk), .sclk_n(sclk_n), .fsync(fsync), .fsync_n(fsync_n),
    .sdata(sdata), .sdata_n(sdata_n), .oor(oor)
  );

  always #(CLK_PER / 2) clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] exp_w [64];
  logic        exp_o [64];
  string       exp_t [64];
  int nset = 1, nfr = 0, ndone = 0, frm = 0, bits = 0;
  bit capturing = 0, have_prev = 0, have_rise = 0, finished = 0;
  logic [15:0] word;
  logic p_sclk, p_fs, p_dat, p_oor;
  int cyc = 0, last_rise = 0, fs_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] sat16(input int v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic string tag_of(input int v);
    if (v > 32767) return "R2";
    if (v < -32768) return "R3";
    return "R1";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(sclk_n == ~sclk && fsync_n == ~fsync && sdata_n == ~sdata, "R9 complements",
          {sclk_n, fsync_n, sdata_n}, {~sclk, ~fsync, ~sdata});
      if (have_prev) begin
        if (oor != p_oor)
          chk(p_sclk && !sclk, "R5 oor moved off falling edge", {p_sclk, sclk}, 2);
        if (sdata != p_dat)
          chk(!p_sclk && sclk, "R7 data moved off rising edge", {p_sclk, sclk}, 1);
        if (fsync != p_fs)
          chk(!p_sclk && sclk, "R7 fsync moved off rising edge", {p_sclk, sclk}, 1);
        if (!p_sclk && sclk) begin
          if (have_rise) chk(cyc - last_rise == DIV, "R6 sclk period", cyc - last_rise, DIV);
          have_rise = 1;
          last_rise = cyc;
        end
        if (p_fs && !fsync) chk(fs_len == DIV, "R6 fsync width", fs_len, DIV);
        if (p_sclk && !sclk) begin
          if (fsync) begin
            frm = nfr;
            nfr++;
            bits = 0;
            capturing = 1;
            if (frm < nset) chk(oor == exp_o[frm], {exp_t[frm], " R4 R5 flag at frame sync"}, oor, exp_o[frm]);
            chk(sdata == 1'b0, "R7 data low in sync slot", sdata, 0);
          end else if (capturing) begin
            word = {word[14:0], sdata};
            bits++;
            if (frm < nset) chk(oor == exp_o[frm], {exp_t[frm], " R5 flag held in frame"}, oor, exp_o[frm]);
            if (bits == 16) begin
              capturing = 0;
              if (frm < nset) begin
                chk(word == exp_w[frm], {exp_t[frm], " R8 word"}, word, exp_w[frm]);
                ndone++;
              end
            end
          end else begin
            chk(0, "R6 data fall outside frame", 0, 1);
          end
        end
      end
      fs_len = fsync ? fs_len + 1 : 0;
      p_sclk = sclk; p_fs = fsync; p_dat = sdata; p_oor = oor;
      have_prev = 1;
    end
  end

  // mode 0: one sample, 1: no sample (resend), 2: decoy then real sample
  task automatic send(input int v, input int mode);
    while (nfr < nset) @(negedge clk);
    repeat (6) @(negedge clk);
    if (mode == 2) begin
      smp_in = IN_W'(-7000000); smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      repeat (3) @(negedge clk);
    end
    if (mode != 1) begin
      smp_in = IN_W'(v); smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      exp_w[nset] = sat16(v);
      exp_o[nset] = (v > 32767) || (v < -32768);
      exp_t[nset] = tag_of(v);
    end else begin
      exp_w[nset] = exp_w[nset-1];
      exp_o[nset] = exp_o[nset-1];
      exp_t[nset] = "R8 resend";
    end
    nset++;
  endtask

  initial begin
    exp_w[0] = 16'h0000; exp_o[0] = 1'b0; exp_t[0] = "R10";
    repeat (3) @(negedge clk);
    chk({sclk, fsync, sdata, oor} == 4'b0000, "R10 reset low outputs", {sclk, fsync, sdata, oor}, 0);
    chk({sclk_n, fsync_n, sdata_n} == 3'b111, "R10 reset complements", {sclk_n, fsync_n, sdata_n}, 7);
    rst_n = 1'b1;
    send(0, 0); send(1, 0); send(-1, 0); send(12345, 0); send(-12345, 0);
    for (int d = -2; d <= 2; d++) send(32767 + d, 0);
    for (int d = -2; d <= 2; d++) send(-32768 + d, 0);
    send(8388607, 0); send(-8388608, 0);
    send(40000, 0); send(-40000, 0); send(5, 0);
    send(0, 1); send(-200, 2); send(0, 1);
    send(70000, 0); send(0, 1); send(32767, 0); send(-32768, 2);
    while (ndone < nset && !finished) @(negedge clk);
    chk(ndone == nset, "R8 all frames received", ndone, nset);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d frames", ndone, nset);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule